// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. It holds a small segment table. Each entry stores a starting physical address (base), a segment length (limit), a valid flag and three access-permission flags: read, write and execute. A length register sets how many leading table entries are currently in use.

Each request is checked in a fixed order. The segment number is checked against the length register first, then the valid flag of the selected entry, then the offset against the entry's limit, and last the requested access kind against the permission flags. The first check that fails sets a trap cause code. If all checks pass, the block grants the access and returns base plus offset. The result appears one clock after the request.

Software loads the table and the length register through a write port. That port only takes effect while the privileged-mode input is high.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, the length register is 0 and no response is pending. A request right after reset therefore traps with cause 1.
- R2: A response (`rsp_valid_o` high) appears exactly one clock after each cycle in which `req_valid_i` is high, and only then. When no response is presented, `grant_o` and `trap_o` are low.
- R3: A segment number greater than or equal to the length register traps with cause 1. This check has the highest priority.
- R4: A segment number within the length whose entry has its valid flag clear traps with cause 2.
- R5: A legal, valid segment whose offset is greater than or equal to the entry limit traps with cause 3. A limit of 0 therefore admits no offset.
- R6: The access code selects the permission flag that must be set: 0 = read (`wr_perm_i` bit 0), 1 = write (bit 1), 2 = execute (bit 2). Code 3 is never permitted. If the needed flag is clear, the request traps with cause 4. This check runs only after R3 to R5 have passed.
- R7: When every check passes, `grant_o` is high, `cause_o` is 0 and `paddr_o` equals (base + offset) modulo 2^PA_W.
- R8: On a trap, `trap_o` is high, `grant_o` is low, `paddr_o` is 0 and `cause_o` is nonzero.
- R9: Writes (entry writes with `wr_sel_i` = 0, length writes with `wr_sel_i` = 1) change state only when `priv_i` is high. Otherwise they have no effect.
- R10: A length write larger than SEG_COUNT stores SEG_COUNT. A segment number at or beyond the table size therefore always traps with cause 1.
- R11: A request made in the same cycle as a write is checked against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Privileged mode; write enable qualifier |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 = write table entry, 1 = write length register |
| wr_idx_i | input | IDX_W (3) | Entry index for entry writes |
| wr_base_i | input | BASE_W (24) | Entry base |
| wr_limit_i | input | OFF_W+1 (17) | Entry limit (segment length) |
| wr_valid_i | input | 1 | Entry valid flag |
| wr_perm_i | input | 3 | Entry permissions: bit0 read, bit1 write, bit2 execute |
| wr_len_i | input | LEN_W (4) | Length register value |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | SEG_NUM_W (4) | Segment number |
| req_off_i | input | OFF_W (16) | Offset within segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid_o | output | 1 | Response present |
| grant_o | output | 1 | Access granted |
| trap_o | output | 1 | Access trapped |
| cause_o | output | 3 | 0 none, 1 segment beyond length, 2 invalid entry, 3 offset beyond limit, 4 permission |
| paddr_o | output | PA_W (24) | Physical address, zero on trap |

## Verification
The assertions assume that reset is held for at least one edge before requests start, and that `req_seg_i` may take any value, including numbers beyond the table. Only the clamped length register keeps those numbers out of the table. The stimulus deasserts every strobe during reset and sweeps all 16 segment numbers and all four access codes, including the reserved one. Every length value from 0 to 8 is covered, and a set of offsets sits at 0, 1, limit-1, limit and the maximum. The expected cause and address are computed from a shadow copy of the accepted writes, so the clamping and the privileged gating are exercised on purpose.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RANGE   = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_BOUND   = 3'd3,
        CAUSE_PERM    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic logic perm_allows(perm_t p, acc_e a);
        logic ok;
        case (a)
            ACC_READ:  ok = p.r;
            ACC_WRITE: ok = p.w;
            ACC_EXEC:  ok = p.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_COUNT = 8,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned LEN_W     = 4,
    parameter int unsigned BASE_W    = 24,
    parameter int unsigned LIM_W     = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_valid,
    input  perm_t             wr_perm,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_valid,
    output perm_t             rd_perm,
    output logic [LEN_W-1:0]  len_q
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(SEG_COUNT);

    logic [BASE_W-1:0] base_q  [SEG_COUNT];
    logic [LIM_W-1:0]  limit_q [SEG_COUNT];
    logic              valid_q [SEG_COUNT];
    perm_t             perm_q  [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        logic hit;
        assign hit = wr_ok && !wr_sel && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                valid_q[g] <= 1'b0;
                perm_q[g]  <= '0;
            end else if (hit) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                valid_q[g] <= wr_valid;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (wr_ok && wr_sel) begin
            len_q <= (wr_len > LEN_MAX) ? LEN_MAX : wr_len;
        end
    end

    always_comb begin
        rd_base  = '0;
        rd_limit = '0;
        rd_valid = 1'b0;
        rd_perm  = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_base  = base_q[i];
                rd_limit = limit_q[i];
                rd_valid = valid_q[i];
                rd_perm  = perm_q[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_NUM_W = 4,
    parameter int unsigned LEN_W     = 4,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned BASE_W    = 24,
    parameter int unsigned PA_W      = 24
) (
    input  logic [SEG_NUM_W-1:0] seg,
    input  logic [OFF_W-1:0]     off,
    input  acc_e                 acc,
    input  logic [LEN_W-1:0]     len,
    input  logic [BASE_W-1:0]    ent_base,
    input  logic [OFF_W:0]       ent_limit,
    input  logic                 ent_valid,
    input  perm_t                ent_perm,
    output cause_e               cause,
    output logic [PA_W-1:0]      paddr
);

    localparam int unsigned CMP_W = (SEG_NUM_W > LEN_W) ? SEG_NUM_W : LEN_W;

    logic in_range;
    logic in_bound;

    assign in_range = CMP_W'(seg) < CMP_W'(len);
    assign in_bound = {1'b0, off} < ent_limit;

    always_comb begin
        if (!in_range) begin
            cause = CAUSE_RANGE;
        end else if (!ent_valid) begin
            cause = CAUSE_INVALID;
        end else if (!in_bound) begin
            cause = CAUSE_BOUND;
        end else if (!perm_allows(ent_perm, acc)) begin
            cause = CAUSE_PERM;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    assign paddr = PA_W'(ent_base) + PA_W'(off);

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
    import seg_xlate_pkg::*;
#(
    parameter int unsigned PA_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  cause_e          cause,
    input  logic [PA_W-1:0] paddr,
    output logic            rsp_valid,
    output logic            grant,
    output logic            trap,
    output logic [2:0]      cause_q,
    output logic [PA_W-1:0] paddr_q
);

    logic fail;
    assign fail = (cause != CAUSE_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            grant     <= 1'b0;
            trap      <= 1'b0;
            cause_q   <= 3'd0;
            paddr_q   <= '0;
        end else begin
            rsp_valid <= req_valid;
            grant     <= req_valid && !fail;
            trap      <= req_valid && fail;
            cause_q   <= req_valid ? 3'(cause) : 3'd0;
            paddr_q   <= (req_valid && !fail) ? paddr : '0;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_COUNT = 8,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned BASE_W    = 24,
    parameter int unsigned PA_W      = 24,
    localparam int unsigned IDX_W     = idx_width(SEG_COUNT),
    localparam int unsigned SEG_NUM_W = IDX_W + 1,
    localparam int unsigned LEN_W     = $clog2(SEG_COUNT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 priv_i,
    input  logic                 wr_en_i,
    input  logic                 wr_sel_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [BASE_W-1:0]    wr_base_i,
    input  logic [OFF_W:0]       wr_limit_i,
    input  logic                 wr_valid_i,
    input  logic [2:0]           wr_perm_i,
    input  logic [LEN_W-1:0]     wr_len_i,
    input  logic                 req_valid_i,
    input  logic [SEG_NUM_W-1:0] req_seg_i,
    input  logic [OFF_W-1:0]     req_off_i,
    input  logic [1:0]           req_acc_i,
    output logic                 rsp_valid_o,
    output logic                 grant_o,
    output logic                 trap_o,
    output logic [2:0]           cause_o,
    output logic [PA_W-1:0]      paddr_o
);

    logic [BASE_W-1:0] ent_base;
    logic [OFF_W:0]    ent_limit;
    logic              ent_valid;
    perm_t             ent_perm;
    logic [LEN_W-1:0]  len_q;
    cause_e            cause;
    logic [PA_W-1:0]   paddr;

    seg_table #(
        .SEG_COUNT(SEG_COUNT), .IDX_W(IDX_W), .LEN_W(LEN_W),
        .BASE_W(BASE_W), .LIM_W(OFF_W + 1)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_en_i && priv_i),
        .wr_sel   (wr_sel_i),
        .wr_idx   (wr_idx_i),
        .wr_base  (wr_base_i),
        .wr_limit (wr_limit_i),
        .wr_valid (wr_valid_i),
        .wr_perm  (perm_t'(wr_perm_i)),
        .wr_len   (wr_len_i),
        .rd_idx   (req_seg_i[IDX_W-1:0]),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_valid (ent_valid),
        .rd_perm  (ent_perm),
        .len_q    (len_q)
    );

    seg_check #(
        .SEG_NUM_W(SEG_NUM_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
        .BASE_W(BASE_W), .PA_W(PA_W)
    ) u_check (
        .seg       (req_seg_i),
        .off       (req_off_i),
        .acc       (acc_e'(req_acc_i)),
        .len       (len_q),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .cause     (cause),
        .paddr     (paddr)
    );

    seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid_i),
        .cause     (cause),
        .paddr     (paddr),
        .rsp_valid (rsp_valid_o),
        .grant     (grant_o),
        .trap      (trap_o),
        .cause_q   (cause_o),
        .paddr_q   (paddr_o)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int unsigned SEG_COUNT = 8,
    parameter int unsigned SEG_NUM_W = 4,
    parameter int unsigned PA_W      = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid_i,
    input logic [SEG_NUM_W-1:0] req_seg_i,
    input logic [1:0]           req_acc_i,
    input logic                 rsp_valid_o,
    input logic                 grant_o,
    input logic                 trap_o,
    input logic [2:0]           cause_o,
    input logic [PA_W-1:0]      paddr_o
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_valid_o && !grant_o && !trap_o));

    // R8
    trap_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (paddr_o == '0 && !grant_o && cause_o != 3'd0));

    // R7
    grant_no_cause_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> (cause_o == 3'd0 && !trap_o));

    // R10
    beyond_table_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_seg_i >= SEG_NUM_W'(SEG_COUNT)) |=> (trap_o && cause_o == 3'd1));

    // R6
    rsvd_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_acc_i == 2'd3) |=> (trap_o && !grant_o));

endmodule

bind seg_xlate seg_xlate_chk #(
    .SEG_COUNT(SEG_COUNT), .SEG_NUM_W(SEG_NUM_W), .PA_W(PA_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_seg_i(req_seg_i),
    .req_acc_i(req_acc_i), .rsp_valid_o(rsp_valid_o), .grant_o(grant_o),
    .trap_o(trap_o), .cause_o(cause_o), .paddr_o(paddr_o)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic [23:0] wr_base_i = '0;
    logic [16:0] wr_limit_i = '0;
    logic        wr_valid_i = 1'b0;
    logic [2:0]  wr_perm_i = '0;
    logic [3:0]  wr_len_i = '0;
    logic        req_valid_i = 1'b0;
    logic [3:0]  req_seg_i = '0;
    logic [15:0] req_off_i = '0;
    logic [1:0]  req_acc_i = '0;
    logic        rsp_valid_o, grant_o, trap_o;
    logic [2:0]  cause_o;
    logic [23:0] paddr_o;

    int n_chk = 0;
    int n_bad = 0;

    // shadow of accepted writes
    logic [23:0] m_base [8];
    logic [16:0] m_lim  [8];
    logic        m_val  [8];
    logic [2:0]  m_perm [8];
    int          m_len;

    always #4 clk = ~clk;

    seg_xlate u0 (.*);

    task automatic check(string tag, logic ok, string act, string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic wr_ent(logic p, int idx, logic [23:0] b, logic [16:0] l, logic v, logic [2:0] pm);
        priv_i = p; wr_en_i = 1; wr_sel_i = 0; wr_idx_i = 3'(idx);
        wr_base_i = b; wr_limit_i = l; wr_valid_i = v; wr_perm_i = pm;
        @(negedge clk);
        wr_en_i = 0; priv_i = 0;
        if (p) begin m_base[idx] = b; m_lim[idx] = l; m_val[idx] = v; m_perm[idx] = pm; end
    endtask

    task automatic wr_len(logic p, int v);
        priv_i = p; wr_en_i = 1; wr_sel_i = 1; wr_len_i = 4'(v);
        @(negedge clk);
        wr_en_i = 0; priv_i = 0;
        if (p) m_len = (v > 8) ? 8 : v;
    endtask

    function automatic int exp_cause(int seg, int off, int acc);
        if (seg >= m_len) return 1;
        if (!m_val[seg]) return 2;
        if (off >= int'(m_lim[seg])) return 3;
        if (acc == 3 || !m_perm[seg][acc]) return 4;
        return 0;
    endfunction

    task automatic req(int seg, int off, int acc, string tag);
        int ec;
        logic [23:0] ea;
        ec = exp_cause(seg, off, acc);
        ea = (ec == 0) ? 24'(m_base[seg] + 24'(off)) : 24'd0;
        req_valid_i = 1; req_seg_i = 4'(seg); req_off_i = 16'(off); req_acc_i = 2'(acc);
        @(negedge clk);
        req_valid_i = 0;
        check(tag, rsp_valid_o && (grant_o == (ec == 0)) && (trap_o == (ec != 0))
                   && cause_o == 3'(ec) && paddr_o == ea,
              $sformatf("v%0b g%0b t%0b c%0d a%h", rsp_valid_o, grant_o, trap_o, cause_o, paddr_o),
              $sformatf("c%0d a%h", ec, ea));
    endtask

    function automatic string tag_for(int c);
        case (c)
            0: return "R7";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lim[i] = 0; m_val[i] = 0; m_perm[i] = 0; end
        m_len = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", !rsp_valid_o && !grant_o && !trap_o && cause_o == 0 && paddr_o == 0,
              $sformatf("v%0b g%0b t%0b", rsp_valid_o, grant_o, trap_o), "all low");
        req(0, 0, 0, "R1");
        // R9: unprivileged writes ignored
        wr_ent(0, 0, 24'h1000, 17'h100, 1, 3'd7);
        wr_len(0, 8);
        req(0, 0, 0, "R9");
        // load table
        wr_ent(1, 0, 24'h001000, 17'h00100, 1, 3'd7);
        wr_ent(1, 1, 24'hFFFF00, 17'h10000, 1, 3'd1);
        wr_ent(1, 2, 24'h002000, 17'h00040, 0, 3'd7);
        wr_ent(1, 3, 24'h030000, 17'h00000, 1, 3'd7);
        wr_ent(1, 4, 24'h000400, 17'h00001, 1, 3'd2);
        wr_ent(1, 5, 24'h005000, 17'h08000, 1, 3'd4);
        wr_ent(1, 6, 24'h123456, 17'h0FFFF, 1, 3'd3);
        wr_ent(1, 7, 24'h7FFFFF, 17'h00002, 1, 3'd6);
        // R10: length saturates
        wr_len(1, 15);
        req(8, 0, 0, "R10");
        req(15, 0, 0, "R10");
        req(7, 1, 1, "R10");
        // R9: unprivileged overwrite of entry 0 ignored
        wr_ent(0, 0, 24'h0, 17'h0, 0, 3'd0);
        req(0, 5, 0, "R9");
        // sweep lengths, segments, accesses, offsets
        for (int len = 0; len <= 8; len++) begin
            wr_len(1, len);
            for (int s = 0; s < 16; s++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int k = 0; k < 5; k++) begin
                        int lim, off;
                        lim = (s < 8) ? int'(m_lim[s]) : 0;
                        case (k)
                            0: off = 0;
                            1: off = 1;
                            2: off = (lim > 0) ? lim - 1 : 0;
                            3: off = (lim > 65535) ? 65535 : lim;
                            default: off = 65535;
                        endcase
                        req(s, off, a, tag_for(exp_cause(s, off, a)));
                    end
                end
            end
        end
        // R11: write and request in the same cycle see the old entry
        priv_i = 1; wr_en_i = 1; wr_sel_i = 0; wr_idx_i = 0;
        wr_base_i = 24'h0; wr_limit_i = 17'h0; wr_valid_i = 0; wr_perm_i = 0;
        req(0, 16, 0, "R11");
        wr_en_i = 0; priv_i = 0;
        m_val[0] = 0; m_lim[0] = 0; m_base[0] = 0; m_perm[0] = 0;
        req(0, 16, 0, "R11");
        // R2: idle cycle gives no response
        @(negedge clk);
        check("R2", !rsp_valid_o && !grant_o && !trap_o,
              $sformatf("v%0b g%0b t%0b", rsp_valid_o, grant_o, trap_o), "000");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule